// File: doc/BRIEF.md
# Broadcast Audio Mode Selector

This block is the routing decision point of a television multichannel sound decoder. It takes three single-bit detector verdicts from the analog front end: stereo pilot found, second-language carrier found, and carrier noise found. It also takes five control bits held by the host. From these it produces registered select codes. The codes choose what feeds the companding noise-reduction path, what drives the left and right line outputs, whether the second-language program is attenuated, whether the external input replaces the decoder, and whether the line outputs are silenced.

The decision is combinational. All outputs leave the block through one register stage, so the downstream analog switches see a single clean transition per change of inputs. A synchronizer releases the asynchronous active-low reset on a clock edge.

Top module: `bam_mode_sel`

## Requirements
- R1: While reset is applied, and until the first decision is registered, the outputs hold nr_src=00, left_src=01, right_src=01, sap_atten=0, ext_route=0 and line_mute=1.
- R2: When the second-language program is not selected and force_mono=0, the selects depend on pilot_det. With pilot_det=1: nr_src=01 (difference signal), left_src=00 (own channel) and right_src=00. With pilot_det=0: nr_src=00 (mute) and left_src=right_src=01 (sum signal).
- R3: When the second-language program is not selected and force_mono=1, the selects are nr_src=00 and left_src=right_src=01, whatever the detector flags are.
- R4: The second-language program is selected only when sap_req=1 and (sap_force=1 or sap_det=1). In every other case the routing is that of R2 or R3.
- R5: When the second-language program is selected and force_mono=0, the selects are nr_src=10 and left_src=right_src=10.
- R6: When the second-language program is selected and force_mono=1, the selects are nr_src=10, left_src=01 and right_src=10.
- R7: sap_atten is 1 exactly when the second-language program is selected and noise_det=1.
- R8: ext_route equals ext_sel and leaves the select codes unchanged.
- R9: line_mute is the inverse of out_enable.
- R10: A change on any input appears on every output at the first rising clock edge after it. All fields change at that same edge and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pilot_det | input | 1 | Stereo pilot detected |
| sap_det | input | 1 | Second-language carrier detected |
| noise_det | input | 1 | Carrier noise detected |
| sap_req | input | 1 | Host requests second-language output |
| force_mono | input | 1 | Host forces mono routing |
| sap_force | input | 1 | Select second language even without carrier |
| ext_sel | input | 1 | Route external input to line outputs |
| out_enable | input | 1 | 1 unmutes line outputs |
| nr_src | output | 2 | Noise-reduction input: 00 mute, 01 difference, 10 second language |
| left_src | output | 2 | Left source: 00 own channel, 01 sum, 10 second language |
| right_src | output | 2 | Right source: 00 own channel, 01 sum, 10 second language |
| sap_atten | output | 1 | Soft attenuation of the second-language program |
| ext_route | output | 1 | External input replaces decoder output |
| line_mute | output | 1 | Line outputs muted |

## Verification
Every result is due one rising edge after its stimulus. The driver changes the inputs at a falling edge and queues the expected outputs. The monitor pops the queue one time unit after the next rising edge, so it compares right after the single register stage updates. Just after each drive, the driver also confirms that the outputs still show the previous expectation, which shows that nothing changes before the clock. The stimulus covers all 256 input words in binary order and again in Gray-code order, so both multi-bit and single-bit transitions are seen.

// File: rtl/bamsel_pkg.sv
package bamsel_pkg;

  localparam int SEL_W = 2;
  localparam int NUM_CH = 2;

  typedef enum logic [SEL_W-1:0] {
    NR_MUTE = 2'b00,
    NR_DIFF = 2'b01,
    NR_SAP  = 2'b10
  } nr_src_e;

  typedef enum logic [SEL_W-1:0] {
    CH_OWN = 2'b00,
    CH_MIX = 2'b01,
    CH_SAP = 2'b10
  } ch_src_e;

  typedef struct packed {
    logic pilot;
    logic carrier;
    logic noise;
    logic sap_req;
    logic mono;
    logic sap_force;
    logic ext;
    logic out_en;
  } mode_in_t;

  typedef struct packed {
    nr_src_e             nr;
    ch_src_e [NUM_CH-1:0] ch;   // index 0 left, 1 right
    logic                atten;
    logic                ext;
    logic                mute;
  } route_t;

  localparam int ROUTE_W = $bits(route_t);

  function automatic route_t route_reset();
    route_t r;
    r.nr    = NR_MUTE;
    r.ch    = {CH_MIX, CH_MIX};
    r.atten = 1'b0;
    r.ext   = 1'b0;
    r.mute  = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/bamsel_rst_sync.sv
module bamsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bamsel_decide.sv
module bamsel_decide
  import bamsel_pkg::*;
(
  input  mode_in_t mode,
  output route_t   route
);

  logic sap_sel;
  logic stereo_ok;

  // second-language path wins when requested and either forced or detected
  assign sap_sel   = mode.sap_req & (mode.sap_force | mode.carrier);
  assign stereo_ok = mode.pilot & ~mode.mono;

  always_comb begin
    if (sap_sel) begin
      route.nr = NR_SAP;
    end else if (stereo_ok) begin
      route.nr = NR_DIFF;
    end else begin
      route.nr = NR_MUTE;
    end
  end

  // per-channel source; only the left side folds to the sum under forced mono
  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    localparam bit FOLD_ON_MONO = (gi == 0);
    always_comb begin
      if (sap_sel) begin
        if (FOLD_ON_MONO && mode.mono) begin
          route.ch[gi] = CH_MIX;
        end else begin
          route.ch[gi] = CH_SAP;
        end
      end else if (stereo_ok) begin
        route.ch[gi] = CH_OWN;
      end else begin
        route.ch[gi] = CH_MIX;
      end
    end
  end

  assign route.atten = sap_sel & mode.noise;
  assign route.ext   = mode.ext;
  assign route.mute  = ~mode.out_en;

endmodule

// File: rtl/bamsel_route_reg.sv
module bamsel_route_reg
  import bamsel_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  route_t route_d,
  output route_t route_q
);

  route_t cur_q;
  route_t nxt;
  logic   load_en;

  always_comb begin
    load_en = (route_d != cur_q);
    nxt     = cur_q;
    if (load_en) begin
      nxt = route_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= route_reset();
    end else if (load_en) begin
      cur_q <= nxt;
    end
  end

  assign route_q = cur_q;

endmodule

// File: rtl/bam_mode_sel.sv
module bam_mode_sel
  import bamsel_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pilot_det,
  input  logic             sap_det,
  input  logic             noise_det,
  input  logic             sap_req,
  input  logic             force_mono,
  input  logic             sap_force,
  input  logic             ext_sel,
  input  logic             out_enable,
  output logic [SEL_W-1:0] nr_src,
  output logic [SEL_W-1:0] left_src,
  output logic [SEL_W-1:0] right_src,
  output logic             sap_atten,
  output logic             ext_route,
  output logic             line_mute
);

  logic     rst_sync_n;
  mode_in_t mode;
  route_t   route_d;
  route_t   route_q;

  bamsel_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    mode.pilot     = pilot_det;
    mode.carrier   = sap_det;
    mode.noise     = noise_det;
    mode.sap_req   = sap_req;
    mode.mono      = force_mono;
    mode.sap_force = sap_force;
    mode.ext       = ext_sel;
    mode.out_en    = out_enable;
  end

  bamsel_decide u_dec (
    .mode (mode),
    .route(route_d)
  );

  bamsel_route_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .route_d(route_d),
    .route_q(route_q)
  );

  assign nr_src    = route_q.nr;
  assign left_src  = route_q.ch[0];
  assign right_src = route_q.ch[1];
  assign sap_atten = route_q.atten;
  assign ext_route = route_q.ext;
  assign line_mute = route_q.mute;

endmodule

// File: rtl/bamsel_chk.sv
module bamsel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sap_req,
  input logic       force_mono,
  input logic       ext_sel,
  input logic       out_enable,
  input logic [1:0] nr_src,
  input logic [1:0] left_src,
  input logic [1:0] right_src,
  input logic       sap_atten,
  input logic       ext_route,
  input logic       line_mute
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
    end
  end

  // R2
  diff_means_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nr_src == 2'b01) |-> (left_src == 2'b00 && right_src == 2'b00));

  // R3
  mono_folds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(force_mono) && nr_src != 2'b10) |->
      (left_src == 2'b01 && right_src == 2'b01));

  // R4
  no_req_no_sap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$past(sap_req)) |-> (nr_src != 2'b10));

  // R5
  sap_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_src == 2'b10) |-> (right_src == 2'b10 && nr_src == 2'b10));

  // R6
  mono_left_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(force_mono)) |-> (left_src != 2'b10));

  // R7
  atten_needs_sap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sap_atten |-> (nr_src == 2'b10));

  // R8
  ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (ext_route == $past(ext_sel)));

  // R9
  mute_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (line_mute == !$past(out_enable)));

  // R10
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nr_src != 2'b11 && left_src != 2'b11 && right_src != 2'b11));

endmodule

bind bam_mode_sel bamsel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sap_req   (sap_req),
  .force_mono(force_mono),
  .ext_sel   (ext_sel),
  .out_enable(out_enable),
  .nr_src    (nr_src),
  .left_src  (left_src),
  .right_src (right_src),
  .sap_atten (sap_atten),
  .ext_route (ext_route),
  .line_mute (line_mute)
);

// File: tb/tb_bam_mode_sel.sv
module tb_bam_mode_sel;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] vec = '0;
  logic [1:0] nr_src, left_src, right_src;
  logic sap_atten, ext_route, line_mute;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef logic [8:0] exp_t; // {nr, left, right, atten, ext, mute}
  exp_t q[$];
  exp_t last_exp;

  always #5 clk = ~clk;

  bam_mode_sel dut (
    .clk(clk), .rst_n(rst_n),
    .pilot_det(vec[0]), .sap_det(vec[1]), .noise_det(vec[2]),
    .sap_req(vec[3]), .force_mono(vec[4]), .sap_force(vec[5]),
    .ext_sel(vec[6]), .out_enable(vec[7]),
    .nr_src(nr_src), .left_src(left_src), .right_src(right_src),
    .sap_atten(sap_atten), .ext_route(ext_route), .line_mute(line_mute)
  );

  function automatic exp_t model(input logic [7:0] v);
    logic sel;
    logic [1:0] n, l, r;
    sel = v[3] && (v[5] || v[1]);
    if (sel) begin
      n = 2'b10; r = 2'b10; l = v[4] ? 2'b01 : 2'b10;
    end else if (!v[4] && v[0]) begin
      n = 2'b01; l = 2'b00; r = 2'b00;
    end else begin
      n = 2'b00; l = 2'b01; r = 2'b01;
    end
    return {n, l, r, sel && v[2], v[6], !v[7]};
  endfunction

  function automatic string tag(input logic [7:0] v);
    logic sel;
    sel = v[3] && (v[5] || v[1]);
    if (v[3] && !v[5]) return "R4";
    if (sel && v[4]) return "R6";
    if (sel) return "R5";
    if (v[4]) return "R3";
    return "R2";
  endfunction

  function automatic exp_t actual();
    return {nr_src, left_src, right_src, sap_atten, ext_route, line_mute};
  endfunction

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one word per cycle, queued for the monitor
  task automatic apply(input logic [7:0] v);
    @(negedge clk);
    vec = v;
    #1;
    cmp("R10", actual(), last_exp); // no change before the clock edge
    q.push_back(model(v) | exp_t'(v) << 9 >> 9);
    last_exp = model(v);
  endtask

  logic [7:0] mon_vec[$];

  // monitor: compares just after the register updates
  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [7:0] v;
      #1;
      e = q.pop_front();
      v = mon_vec.pop_front();
      cmp(tag(v), {nr_src, left_src, right_src}, e[8:3]);
      cmp("R7", sap_atten, e[2]);
      cmp("R8", ext_route, e[1]);
      cmp("R9", line_mute, e[0]);
    end
  end

  task automatic send(input logic [7:0] v);
    mon_vec.push_back(v);
    apply(v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    last_exp = {2'b00, 2'b01, 2'b01, 1'b0, 1'b0, 1'b1};
    repeat (3) @(negedge clk);
    cmp("R1", actual(), last_exp);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    cmp("R1", actual(), last_exp);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      send(8'(i));
    end
    for (int i = 0; i < 256; i++) begin
      send(8'(i ^ (i >> 1)));
    end
    // targeted corners
    send(8'b1000_1010); // R4 carrier present, request on
    send(8'b1000_1000); // R4 request, no carrier, no force
    send(8'b1001_1111); // R6 with noise
    send(8'b1100_0001); // R8 stereo with external route
    send(8'b0000_0001); // R9 muted stereo
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule